// File: doc/BRIEF.md
# Wide-Issue Instruction Fetch Buffer

This block sits between a line-oriented instruction cache and a four-wide in-order issue stage. Each cycle it can take one cache line of fixed-length 32-bit instructions. The line may be entered part-way through, at a word offset supplied with it, and only the words from that offset to the end of the line are kept. The buffer holds up to eight instructions, which is twice the issue width. It always presents its four oldest entries to the issue stage, each with a valid flag.

The issue stage reports how many of the presented instructions it took in the cycle, from zero to four. Those entries leave oldest first, and the survivors move up to the head in the same cycle. The fetch side sees a ready signal that says whether the line it is offering, given its offset, fits in the free space. A short flag tells issue when fewer than a full group of four instructions is held. A flush input discards everything, for example after a branch misprediction.

Top module: `fbuf_top`

## Requirements
- R1: After reset the buffer is empty: all four lane valid flags are low, the short flag is high and the ready output is high for any offset.
- R2: Lane i (i = 0 to 3) is valid exactly when the buffer holds more than i entries. Lane 0 carries the oldest entry, lane 1 the next oldest, and so on.
- R3: The short flag is high exactly when fewer than four entries are held.
- R4: An accepted line with offset o (0 to 3) appends the words at positions o through 3 to the tail, in ascending position order. Word p is bits [32p+31:32p] of the line data input.
- R5: The ready output is high exactly when the free entries, counted before this cycle's consumption, are at least 4 minus the offset input. A line offered while ready is low is not stored.
- R6: A consume count n removes the min(n, held) oldest entries. The remaining entries shift to the head in the same cycle, and a count larger than the number held leaves the buffer empty.
- R7: Consumption and an accepted line in the same cycle both take effect: the new content is the survivors followed by the new words.
- R8: A flush empties the buffer by the next cycle. It overrides a line or a consume count offered in the same cycle.
- R9: The buffer never holds more than eight entries. A line that exactly fills the last free entries is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard all held instructions |
| line_valid_i | input | 1 | A cache line is offered this cycle |
| line_offset_i | input | 2 | Word position of the first wanted instruction in the line |
| line_data_i | input | 128 | Cache line, word p at bits [32p+31:32p] |
| line_ready_o | output | 1 | The offered line fits in the free space |
| consume_i | input | 3 | Number of presented instructions taken by issue (0 to 4) |
| issue_valid_o | output | 4 | Per-lane valid flags, lane 0 oldest |
| issue_data_o | output | 128 | Four oldest instructions, lane i at bits [32i+31:32i] |
| issue_short_o | output | 1 | Fewer than four instructions held |

## Verification
The hardest state to reach is a nearly full buffer, where the ready decision depends on the offset offered in that same cycle and consumption is happening at the same time. The stimulus therefore fills the buffer on purpose with lines at offsets 0, 2 and 3. It then offers a line that must be refused and a one-word line that exactly fills the buffer. After that it combines consumption with an enqueue in one cycle, and lands a flush on a cycle that also carries a line and a full consume count. A long random phase follows, with a low consume rate so the full region is visited again and again. A behavioural queue model is compared on every cycle throughout.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
    localparam int unsigned FB_DATA_W  = 32;
    localparam int unsigned FB_LINE_W  = 4;
    localparam int unsigned FB_ISSUE_W = 4;
    localparam int unsigned FB_DEPTH   = 2 * FB_ISSUE_W;
endpackage

// File: rtl/fbuf_ctrl.sv
module fbuf_ctrl
    import fbuf_pkg::*;
#(
    parameter int unsigned DEPTH   = FB_DEPTH,
    parameter int unsigned LINE_W  = FB_LINE_W,
    parameter int unsigned ISSUE_W = FB_ISSUE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         line_valid_i,
    input  logic [$clog2(LINE_W)-1:0]    line_offset_i,
    input  logic [$clog2(ISSUE_W+1)-1:0] consume_i,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
    output logic [$clog2(DEPTH+1)-1:0]   deq_o,
    output logic [$clog2(DEPTH+1)-1:0]   enq_o,
    output logic                         ready_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctrl_s;

    ctrl_s            st_d, st_q;
    logic [CNT_W-1:0] avail;
    logic [CNT_W-1:0] free_n;
    logic [CNT_W-1:0] cons_w;

    always_comb begin
        avail   = CNT_W'(LINE_W) - CNT_W'(line_offset_i);
        free_n  = CNT_W'(DEPTH) - st_q.cnt;
        cons_w  = CNT_W'(consume_i);
        ready_o = (free_n >= avail);
        deq_o   = (cons_w > st_q.cnt) ? st_q.cnt : cons_w;
        enq_o   = (line_valid_i && ready_o) ? avail : '0;
        st_d    = st_q;
        if (flush_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt - deq_o + enq_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/fbuf_store.sv
module fbuf_store
    import fbuf_pkg::*;
#(
    parameter int unsigned DEPTH  = FB_DEPTH,
    parameter int unsigned LINE_W = FB_LINE_W,
    parameter int unsigned DATA_W = FB_DATA_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush_i,
    input  logic [$clog2(DEPTH+1)-1:0]       cnt_i,
    input  logic [$clog2(DEPTH+1)-1:0]       deq_i,
    input  logic [$clog2(DEPTH+1)-1:0]       enq_i,
    input  logic [$clog2(LINE_W)-1:0]        line_offset_i,
    input  logic [LINE_W*DATA_W-1:0]         line_data_i,
    output logic [DEPTH-1:0][DATA_W-1:0]     slots_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned OFF_W = $clog2(LINE_W);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slot;
    } store_s;

    store_s                  st_d, st_q;
    logic [DATA_W-1:0]       line_w [LINE_W];
    logic [CNT_W-1:0]        keep;
    logic [CNT_W-1:0]        k;

    for (genvar p = 0; p < LINE_W; p++) begin : g_unpack
        assign line_w[p] = line_data_i[p*DATA_W +: DATA_W];
    end

    always_comb begin
        st_d = st_q;
        keep = cnt_i - deq_i;
        k    = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (flush_i) begin
                st_d.slot[j] = '0;
            end else if (CNT_W'(j) < keep) begin
                st_d.slot[j] = st_q.slot[IDX_W'(j + int'(deq_i))];
            end else begin
                k = CNT_W'(j) - keep;
                if (k < enq_i) begin
                    st_d.slot[j] = line_w[OFF_W'(int'(line_offset_i) + int'(k))];
                end else begin
                    st_d.slot[j] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slots_o = st_q.slot;
endmodule

// File: rtl/fbuf_top.sv
module fbuf_top
    import fbuf_pkg::*;
#(
    parameter int unsigned DATA_W  = FB_DATA_W,
    parameter int unsigned LINE_W  = FB_LINE_W,
    parameter int unsigned ISSUE_W = FB_ISSUE_W,
    parameter int unsigned DEPTH   = FB_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         line_valid_i,
    input  logic [$clog2(LINE_W)-1:0]    line_offset_i,
    input  logic [LINE_W*DATA_W-1:0]     line_data_i,
    output logic                         line_ready_o,
    input  logic [$clog2(ISSUE_W+1)-1:0] consume_i,
    output logic [ISSUE_W-1:0]           issue_valid_o,
    output logic [ISSUE_W*DATA_W-1:0]    issue_data_o,
    output logic                         issue_short_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             deq_n;
    logic [CNT_W-1:0]             enq_n;
    logic [DEPTH-1:0][DATA_W-1:0] slots;

    fbuf_ctrl #(
        .DEPTH  (DEPTH),
        .LINE_W (LINE_W),
        .ISSUE_W(ISSUE_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .line_valid_i (line_valid_i),
        .line_offset_i(line_offset_i),
        .consume_i    (consume_i),
        .cnt_o        (cnt_q),
        .deq_o        (deq_n),
        .enq_o        (enq_n),
        .ready_o      (line_ready_o)
    );

    fbuf_store #(
        .DEPTH (DEPTH),
        .LINE_W(LINE_W),
        .DATA_W(DATA_W)
    ) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .cnt_i        (cnt_q),
        .deq_i        (deq_n),
        .enq_i        (enq_n),
        .line_offset_i(line_offset_i),
        .line_data_i  (line_data_i),
        .slots_o      (slots)
    );

    for (genvar i = 0; i < ISSUE_W; i++) begin : g_lane
        assign issue_valid_o[i]                  = (cnt_q > CNT_W'(i));
        assign issue_data_o[i*DATA_W +: DATA_W]  = slots[i];
    end

    assign issue_short_o = (cnt_q < CNT_W'(ISSUE_W));
endmodule

// File: rtl/fbuf_chk.sv
module fbuf_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ISSUE_W = 4,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned CONS_W  = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      flush_i,
    input logic                      line_valid_i,
    input logic                      line_ready_o,
    input logic [CONS_W-1:0]         consume_i,
    input logic [ISSUE_W-1:0]        issue_valid_o,
    input logic [ISSUE_W*DATA_W-1:0] issue_data_o,
    input logic                      issue_short_o,
    input logic [CNT_W-1:0]          cnt_q
);
    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (issue_valid_o == '0));

    // R9
    cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R3
    short_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_short_o == !issue_valid_o[ISSUE_W-1]);

    // R2
    valid_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_valid_o + 1'b1) & issue_valid_o) == '0);

    // R5
    refused_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && line_valid_i && !line_ready_o && consume_i == '0) |=> (cnt_q == $past(cnt_q)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !line_valid_i && consume_i == '0) |=> $stable(issue_data_o));
endmodule

bind fbuf_top fbuf_chk #(
    .DATA_W (DATA_W),
    .ISSUE_W(ISSUE_W),
    .DEPTH  (DEPTH),
    .CNT_W  ($clog2(DEPTH + 1)),
    .CONS_W ($clog2(ISSUE_W + 1))
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .line_valid_i (line_valid_i),
    .line_ready_o (line_ready_o),
    .consume_i    (consume_i),
    .issue_valid_o(issue_valid_o),
    .issue_data_o (issue_data_o),
    .issue_short_o(issue_short_o),
    .cnt_q        (cnt_q)
);

// File: tb/fbuf_top_tb_top.sv
module fbuf_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush_i = 1'b0;
    logic         line_valid_i = 1'b0;
    logic [1:0]   line_offset_i = '0;
    logic [127:0] line_data_i = '0;
    logic         line_ready_o;
    logic [2:0]   consume_i = '0;
    logic [3:0]   issue_valid_o;
    logic [127:0] issue_data_o;
    logic         issue_short_o;

    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;
    int          line_seq = 0;
    logic [31:0] q [$];

    always #4 clk = ~clk;

    fbuf_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .line_valid_i (line_valid_i),
        .line_offset_i(line_offset_i),
        .line_data_i  (line_data_i),
        .line_ready_o (line_ready_o),
        .consume_i    (consume_i),
        .issue_valid_o(issue_valid_o),
        .issue_data_o (issue_data_o),
        .issue_short_o(issue_short_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit fl, input bit lv, input int off, input int cons, input string tag);
        bit exp_rdy;
        int n;
        flush_i       = fl;
        line_valid_i  = lv;
        line_offset_i = 2'(off);
        consume_i     = 3'(cons);
        for (int p = 0; p < 4; p++) line_data_i[p*32 +: 32] = 32'hA000_0000 + 32'(line_seq * 4 + p);
        line_seq++;
        #1;
        exp_rdy = ((8 - q.size()) >= (4 - off));
        chk(line_ready_o == exp_rdy, "R5 ready", 32'(line_ready_o), 32'(exp_rdy));
        for (int i = 0; i < 4; i++) begin
            chk(issue_valid_o[i] == (i < q.size()), "R2 valid", 32'(issue_valid_o[i]), 32'(i < q.size()));
            if (i < q.size()) chk(issue_data_o[i*32 +: 32] == q[i], tag, issue_data_o[i*32 +: 32], q[i]);
        end
        chk(issue_short_o == (q.size() < 4), "R3 short", 32'(issue_short_o), 32'(q.size() < 4));
        @(posedge clk);
        if (fl) begin
            q.delete();
        end else begin
            n = (cons > q.size()) ? q.size() : cons;
            for (int i = 0; i < n; i++) void'(q.pop_front());
            if (lv && exp_rdy)
                for (int p = off; p < 4; p++) q.push_back(line_data_i[p*32 +: 32]);
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(issue_valid_o == 4'b0, "R1 valid", 32'(issue_valid_o), 0);
        chk(issue_short_o == 1'b1, "R1 short", 32'(issue_short_o), 1);
        chk(line_ready_o == 1'b1, "R1 ready", 32'(line_ready_o), 1);
        step(0, 1, 0, 0, "R4 data");
        step(0, 1, 2, 0, "R4 data");
        step(0, 1, 3, 0, "R4 data");
        step(0, 1, 0, 0, "R5 data");   // refused: 1 free, 4 wanted
        step(0, 1, 3, 0, "R9 data");   // exactly fills to 8
        #1;
        chk(line_ready_o == 1'b0, "R9 full ready", 32'(line_ready_o), 0);
        step(0, 0, 0, 3, "R6 data");   // 8 -> 5
        step(0, 1, 2, 2, "R7 data");   // 5 - 2 + 2 = 5
        chk(issue_short_o == 1'b0 && issue_valid_o == 4'hF, "R7 count", 32'(issue_valid_o), 32'hF);
        step(1, 1, 0, 4, "R8 data");   // flush wins
        chk(issue_valid_o == 4'b0, "R8 empty", 32'(issue_valid_o), 0);
        step(0, 0, 0, 4, "R6 data");   // consume on empty clamps
        chk(issue_valid_o == 4'b0, "R6 clamp", 32'(issue_valid_o), 0);
        step(0, 1, 1, 0, "R4 data");
        step(0, 0, 0, 4, "R6 data");   // consume 4 of 3
        chk(issue_valid_o == 4'b0, "R6 overclamp", 32'(issue_valid_o), 0);
        for (int c = 0; c < 6000; c++) begin
            step($urandom_range(0, 99) < 3, $urandom_range(0, 99) < 75,
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 4)) / (1 + int'($urandom_range(0, 1))),
                 "R7 data");
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule